// File: doc/BRIEF.md
# Golden-angle Givens rotation pipeline

This block applies a fixed orthogonal transform to a vector of DIM signed fixed-point elements. The transform is a cascade of three layers of plane rotations. Each layer works on disjoint index pairs, so every layer is orthogonal on its own. The first layer pairs neighbours. The second pairs neighbours shifted by one place. The third is a butterfly whose partner sits a quarter of the vector away. The rotation angle of each pair grows in golden-angle steps: G·(k+1) scaled by 1, φ or φ² for the three layers, where G = 2π/φ² (about 137.508°).

One vector enters per cycle on a valid/ready stream, and the rotated vector leaves three register stages later. A per-vector direction bit selects the forward transform or its inverse. The inverse runs the layers in reverse order and negates every sine, so both directions share one coefficient table. The table holds a Q1.15 cosine and sine for every pair. It reaches the block as a constant bus that is tied off at integration. The values are generated off-line, so the datapath contains no random source and repeated runs give identical bits.

Top module: `gr_rot_pipe`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `out_valid` is 0, and `in_ready` is 1 whenever `out_valid` is 0.
- R2: The adjacent layer rotates pairs (2k, 2k+1) for k = 0..DIM/2-1 using table entry k.
- R3: The shifted layer rotates pairs (2k+1, 2k+2) for k = 0..DIM/2-2 using table entry DIM/2+k, and passes elements 0 and DIM-1 through unchanged.
- R4: The butterfly layer walks k = 0..DIM-1 and rotates (k, k+DIM/4 mod DIM) only when neither index has already been taken in that layer (DIM a multiple of 8). The taken pairs use table entries DIM-1, DIM, ... in increasing k.
- R5: For a pair (x_i, x_j) with cosine c and sine s, the outputs are x_i' = c·x_i - s·x_j and x_j' = s·x_i + c·x_j. Each output is shifted right by 15 with round half up, then saturated to the signed 16-bit range (Q2.14 data).
- R6: With `in_inverse`=1 the layers run butterfly, shifted, adjacent, each with the sine negated. A forward pass followed by an inverse pass returns every element within 8 LSB.
- R7: A vector accepted at a clock edge appears on `out_vec` after the third edge from it (three register stages). Back-to-back vectors are accepted and delivered one per cycle.
- R8: While `out_valid`=1 and `out_ready`=0, the output holds `out_vec` and `out_inverse` stable, and no vector is lost or duplicated.
- R9: `out_inverse` equals the `in_inverse` value that was accepted with the same vector.
- R10: A forward pass keeps the squared norm of the vector within 1/256 relative (plus 65536 absolute) of its input value.
- R11: Table entry n sits in `coef_rom[n*32 +: 32]`: the cosine in bits [31:16] and the sine in bits [15:0], both signed Q1.15. A sine of -32768 is not allowed.
- R12: The same input vector, direction and table always produce the same output bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input vector present |
| in_ready | output | 1 | Block can take a vector this cycle |
| in_inverse | input | 1 | 1 selects the inverse transform for this vector |
| in_vec | input | DIM*DW | Input elements, element i at [i*DW +: DW], Q2.14 |
| coef_rom | input | (3*DIM/2-1)*2*CW | Constant cosine/sine table |
| out_valid | output | 1 | Output vector present |
| out_ready | input | 1 | Consumer takes the output this cycle |
| out_inverse | output | 1 | Direction tag of the output vector |
| out_vec | output | DIM*DW | Rotated elements, same layout as the input |

## Verification
Single-element impulses at the first and last positions expose the pair wiring of each layer and the pass-through ends of the shifted layer, because the energy from one element spreads only along the pairs that really exist. Ramps, alternating full-scale values and pseudo-random vectors are compared bit-exactly against an independent model in both directions. This separates a wrong angle entry, a wrong sine sign or a wrong layer order from a rounding fault. A 45° table driven with full-scale input forces the saturation path. Round trips and norm checks show that the cascade stays orthogonal, and streams with and without output stalls show the latency, the throughput and the hold behaviour.

// File: rtl/gr_pkg.sv
package gr_pkg;

  // Layer identifiers; the order of application in forward mode.
  localparam int LYR_ADJ   = 0;
  localparam int LYR_SHIFT = 1;
  localparam int LYR_BFLY  = 2;

  // Number of rotation pairs in a layer.
  function automatic int lyr_pairs(input int lyr, input int dim);
    if (lyr == LYR_SHIFT) return dim / 2 - 1;
    return dim / 2;
  endfunction

  // First coefficient-table entry of a layer.
  function automatic int lyr_base(input int lyr, input int dim);
    if (lyr == LYR_ADJ)   return 0;
    if (lyr == LYR_SHIFT) return dim / 2;
    return dim - 1;
  endfunction

  // Butterfly: index k owns a pair when it lies in an even quarter-block.
  function automatic bit bfly_used(input int k, input int q);
    return ((k / q) % 2) == 0;
  endfunction

  // Butterfly: table slot of an owning index k, counted within the layer.
  function automatic int bfly_slot(input int k, input int q);
    return (k / (2 * q)) * q + (k % q);
  endfunction

endpackage

// File: rtl/gr_rot2.sv
// One plane rotation: two products per output, shared rounding and saturation.
module gr_rot2 #(
  parameter int DW = 16,
  parameter int CW = 16
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic [CW-1:0] c,
  input  logic [CW-1:0] s,
  input  logic          neg,
  output logic [DW-1:0] ya,
  output logic [DW-1:0] yb
);
  localparam int PW = DW + CW;
  localparam int FR = CW - 1;
  localparam logic signed [PW:0] HALF = (PW+1)'(1) <<< (FR - 1);
  localparam logic signed [PW:0] MAXV = (PW+1)'((1 <<< (DW - 1)) - 1);
  localparam logic signed [PW:0] MINV = -MAXV - 1;

  logic signed [CW-1:0] cs, ss;
  logic signed [PW-1:0] p_ca, p_sb, p_sa, p_cb;
  logic signed [PW:0]   acc_a, acc_b;

  function automatic logic [DW-1:0] rnd_sat(input logic signed [PW:0] acc);
    logic signed [PW:0] r;
    r = (acc + HALF) >>> FR;
    if (r > MAXV) return MAXV[DW-1:0];
    if (r < MINV) return MINV[DW-1:0];
    return r[DW-1:0];
  endfunction

  always_comb begin
    cs    = $signed(c);
    ss    = neg ? -$signed(s) : $signed(s);
    p_ca  = cs * $signed(a);
    p_sb  = ss * $signed(b);
    p_sa  = ss * $signed(a);
    p_cb  = cs * $signed(b);
    acc_a = {p_ca[PW-1], p_ca} - {p_sb[PW-1], p_sb};
    acc_b = {p_sa[PW-1], p_sa} + {p_cb[PW-1], p_cb};
    ya    = rnd_sat(acc_a);
    yb    = rnd_sat(acc_b);
  end
endmodule

// File: rtl/gr_layer.sv
// Combinational rotation layer; LAYER picks the pair pattern.
module gr_layer import gr_pkg::*; #(
  parameter int DIM   = 16,
  parameter int DW    = 16,
  parameter int CW    = 16,
  parameter int LAYER = 0,
  localparam int NPL  = lyr_pairs(LAYER, DIM),
  localparam int Q    = DIM / 4
) (
  input  logic [DIM*DW-1:0]   vec_i,
  input  logic [NPL*2*CW-1:0] coef,
  input  logic                neg,
  output logic [DIM*DW-1:0]   vec_o
);
  if (LAYER == LYR_ADJ) begin : g_adj
    for (genvar k = 0; k < DIM / 2; k++) begin : g_p
      gr_rot2 #(.DW(DW), .CW(CW)) u_rot (
        .a(vec_i[(2*k)*DW +: DW]), .b(vec_i[(2*k+1)*DW +: DW]),
        .c(coef[k*2*CW + CW +: CW]), .s(coef[k*2*CW +: CW]), .neg(neg),
        .ya(vec_o[(2*k)*DW +: DW]), .yb(vec_o[(2*k+1)*DW +: DW]));
    end
  end else if (LAYER == LYR_SHIFT) begin : g_shift
    assign vec_o[0 +: DW]            = vec_i[0 +: DW];
    assign vec_o[(DIM-1)*DW +: DW]   = vec_i[(DIM-1)*DW +: DW];
    for (genvar k = 0; k < DIM / 2 - 1; k++) begin : g_p
      gr_rot2 #(.DW(DW), .CW(CW)) u_rot (
        .a(vec_i[(2*k+1)*DW +: DW]), .b(vec_i[(2*k+2)*DW +: DW]),
        .c(coef[k*2*CW + CW +: CW]), .s(coef[k*2*CW +: CW]), .neg(neg),
        .ya(vec_o[(2*k+1)*DW +: DW]), .yb(vec_o[(2*k+2)*DW +: DW]));
    end
  end else begin : g_bfly
    for (genvar k = 0; k < DIM; k++) begin : g_k
      if (bfly_used(k, Q)) begin : g_p
        localparam int J = bfly_slot(k, Q);
        gr_rot2 #(.DW(DW), .CW(CW)) u_rot (
          .a(vec_i[k*DW +: DW]), .b(vec_i[(k+Q)*DW +: DW]),
          .c(coef[J*2*CW + CW +: CW]), .s(coef[J*2*CW +: CW]), .neg(neg),
          .ya(vec_o[k*DW +: DW]), .yb(vec_o[(k+Q)*DW +: DW]));
      end
    end
  end
endmodule

// File: rtl/gr_stage.sv
// One register stage: forward layer FWD_L or inverse layer INV_L per vector.
module gr_stage import gr_pkg::*; #(
  parameter int DIM   = 16,
  parameter int DW    = 16,
  parameter int CW    = 16,
  parameter int FWD_L = 0,
  parameter int INV_L = 2,
  localparam int NF   = lyr_pairs(FWD_L, DIM),
  localparam int NB   = lyr_pairs(INV_L, DIM)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en,
  input  logic                v_i,
  input  logic                inv_i,
  input  logic [DIM*DW-1:0]   vec_i,
  input  logic [NF*2*CW-1:0]  coef_f,
  input  logic [NB*2*CW-1:0]  coef_b,
  output logic                v_o,
  output logic                inv_o,
  output logic [DIM*DW-1:0]   vec_o
);
  logic [DIM*DW-1:0] res;

  if (FWD_L == INV_L) begin : g_same
    logic unused_coef_b;
    assign unused_coef_b = ^coef_b;
    gr_layer #(.DIM(DIM), .DW(DW), .CW(CW), .LAYER(FWD_L)) u_lyr (
      .vec_i(vec_i), .coef(coef_f), .neg(inv_i), .vec_o(res));
  end else begin : g_two
    logic [DIM*DW-1:0] res_f, res_b;
    gr_layer #(.DIM(DIM), .DW(DW), .CW(CW), .LAYER(FWD_L)) u_fwd (
      .vec_i(vec_i), .coef(coef_f), .neg(1'b0), .vec_o(res_f));
    gr_layer #(.DIM(DIM), .DW(DW), .CW(CW), .LAYER(INV_L)) u_inv (
      .vec_i(vec_i), .coef(coef_b), .neg(1'b1), .vec_o(res_b));
    assign res = inv_i ? res_b : res_f;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v_o   <= 1'b0;
      inv_o <= 1'b0;
    end else if (en) begin
      v_o   <= v_i;
      inv_o <= inv_i;
    end
  end

  always_ff @(posedge clk) begin
    if (en) vec_o <= res;
  end
endmodule

// File: rtl/gr_rot_pipe.sv
// Three-stage golden-angle Givens rotation pipeline with valid/ready stream.
module gr_rot_pipe import gr_pkg::*; #(
  parameter int DIM = 16,
  parameter int DW  = 16,
  parameter int CW  = 16,
  localparam int NP = 3 * DIM / 2 - 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic                in_inverse,
  input  logic [DIM*DW-1:0]   in_vec,
  input  logic [NP*2*CW-1:0]  coef_rom,
  output logic                out_valid,
  input  logic                out_ready,
  output logic                out_inverse,
  output logic [DIM*DW-1:0]   out_vec
);
  localparam int NST = 3;

  logic                        adv;
  logic [NST:0]                vv, vi;
  logic [NST:0][DIM*DW-1:0]    vq;

  assign adv      = !vv[NST] || out_ready;
  assign in_ready = adv;
  assign vv[0]    = in_valid;
  assign vi[0]    = in_inverse;
  assign vq[0]    = in_vec;

  for (genvar st = 0; st < NST; st++) begin : g_st
    localparam int FL = st;
    localparam int IL = NST - 1 - st;
    localparam int FB = lyr_base(FL, DIM);
    localparam int FN = lyr_pairs(FL, DIM);
    localparam int IB = lyr_base(IL, DIM);
    localparam int IN = lyr_pairs(IL, DIM);
    gr_stage #(.DIM(DIM), .DW(DW), .CW(CW), .FWD_L(FL), .INV_L(IL)) u_stage (
      .clk(clk), .rst(rst), .en(adv),
      .v_i(vv[st]), .inv_i(vi[st]), .vec_i(vq[st]),
      .coef_f(coef_rom[FB*2*CW +: FN*2*CW]),
      .coef_b(coef_rom[IB*2*CW +: IN*2*CW]),
      .v_o(vv[st+1]), .inv_o(vi[st+1]), .vec_o(vq[st+1]));
  end

  assign out_valid   = vv[NST];
  assign out_inverse = vi[NST];
  assign out_vec     = vq[NST];
endmodule

// File: rtl/gr_rot_pipe_chk.sv
// Protocol checker for gr_rot_pipe.
module gr_rot_pipe_chk #(
  parameter int DIM = 16,
  parameter int DW  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic              out_inverse,
  input logic [DIM*DW-1:0] out_vec
);
  logic [2:0] occ;
  logic       acc, del;

  assign acc = in_valid && in_ready;
  assign del = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (rst) occ <= 3'd0;
    else     occ <= occ + 3'(acc) - 3'(del);
  end

  // R1: output idle right after reset
  a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !out_valid);

  // R8: stalled output data held
  a_r8_stall_hold: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_vec)));

  // R9: stalled direction tag held
  a_r9_tag_hold: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> $stable(out_inverse));

  // R7: never more vectors in flight than register stages
  a_r7_occupancy: assert property (@(posedge clk) disable iff (rst)
    occ <= 3'd3);

  // R8: every delivered vector was accepted earlier
  a_r8_no_phantom: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (occ != 3'd0));
endmodule

bind gr_rot_pipe gr_rot_pipe_chk #(.DIM(DIM), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_inverse(out_inverse),
  .out_vec(out_vec));

// File: tb/gr_rot_pipe_tb_top.sv
module gr_rot_pipe_tb_top;
  localparam int DIM = 16;
  localparam int DW  = 16;
  localparam int CW  = 16;
  localparam int NP  = 3 * DIM / 2 - 1;
  localparam int Q   = DIM / 4;

  typedef int vec_t [DIM];

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic                in_valid = 1'b0, in_inverse = 1'b0, out_ready = 1'b1;
  logic                in_ready, out_valid, out_inverse;
  logic [DIM*DW-1:0]   in_vec = '0;
  logic [DIM*DW-1:0]   out_vec;
  logic [NP*2*CW-1:0]  coef = '0;

  gr_rot_pipe #(.DIM(DIM), .DW(DW), .CW(CW)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_inverse(in_inverse), .in_vec(in_vec), .coef_rom(coef),
    .out_valid(out_valid), .out_ready(out_ready), .out_inverse(out_inverse),
    .out_vec(out_vec));

  int     n_chk = 0, n_fail = 0, pops = 0, lcg = 12345;
  longint cyc = 0, first_pop = 0, last_pop = 0, acc_cyc = 0;
  bit     stall_en = 1'b0, held = 1'b0;
  string  tag = "";
  logic [DIM*DW:0]   expq[$];
  logic [DIM*DW:0]   exp_e;
  logic [DIM*DW-1:0] held_vec;
  vec_t   last_out;

  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk) begin
    #1;
    out_ready = stall_en ? (cyc[0] ^ cyc[1]) : 1'b1;
  end

  // ---------------- helpers ----------------
  function automatic logic [DIM*DW-1:0] pack(input vec_t v);
    logic [DIM*DW-1:0] p;
    for (int i = 0; i < DIM; i++) p[i*DW +: DW] = v[i][DW-1:0];
    return p;
  endfunction

  function automatic void unpack(input logic [DIM*DW-1:0] p, output vec_t v);
    for (int i = 0; i < DIM; i++) v[i] = int'($signed(p[i*DW +: DW]));
  endfunction

  function automatic int rsat(input longint acc);
    longint r;
    r = (acc + 64'sd16384) >>> 15;
    if (r > 32767) return 32767;
    if (r < -32768) return -32768;
    return int'(r);
  endfunction

  function automatic logic [15:0] q15(input real x);
    int v;
    v = (x >= 0.0) ? $rtoi(x * 32768.0 + 0.5) : -$rtoi(-x * 32768.0 + 0.5);
    if (v > 32767) v = 32767;
    if (v < -32767) v = -32767;
    return v[15:0];
  endfunction

  function automatic void rot(inout vec_t v, input int i, input int j,
                              input int idx, input bit neg);
    longint c, s, a, b;
    c = longint'($signed(coef[idx*32 + 16 +: 16]));
    s = longint'($signed(coef[idx*32 +: 16]));
    if (neg) s = -s;
    a = longint'(v[i]);
    b = longint'(v[j]);
    v[i] = rsat(c * a - s * b);
    v[j] = rsat(s * a + c * b);
  endfunction

  function automatic void layer(inout vec_t v, input int lyr, input bit neg);
    bit used [DIM];
    int jn;
    if (lyr == 0) begin
      for (int k = 0; k < DIM / 2; k++) rot(v, 2*k, 2*k+1, k, neg);
    end else if (lyr == 1) begin
      for (int k = 0; k < DIM / 2 - 1; k++) rot(v, 2*k+1, 2*k+2, DIM/2 + k, neg);
    end else begin
      jn = 0;
      for (int k = 0; k < DIM; k++) used[k] = 1'b0;
      for (int k = 0; k < DIM; k++) begin
        if (!used[k] && !used[(k+Q) % DIM]) begin
          used[k] = 1'b1;
          used[(k+Q) % DIM] = 1'b1;
          rot(v, k, (k+Q) % DIM, DIM - 1 + jn, neg);
          jn++;
        end
      end
    end
  endfunction

  function automatic void model(input vec_t v, input bit inv, output vec_t r);
    r = v;
    if (!inv) begin
      for (int l = 0; l < 3; l++) layer(r, l, 1'b0);
    end else begin
      for (int l = 2; l >= 0; l--) layer(r, l, 1'b1);
    end
  endfunction

  function automatic longint norm2(input vec_t v);
    longint n = 0;
    for (int i = 0; i < DIM; i++) n += longint'(v[i]) * longint'(v[i]);
    return n;
  endfunction

  task automatic check(input bit ok, input string what, input longint act, input longint exv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exv);
    end
  endtask

  task automatic golden_rom();
    real phi, g, ang, mult;
    int  jn;
    bit  used [DIM];
    phi = (1.0 + $sqrt(5.0)) / 2.0;
    g   = 2.0 * 3.14159265358979323846 / (phi * phi);
    for (int k = 0; k < DIM / 2; k++) begin
      ang = g * (k + 1);
      coef[k*32 +: 32] = {q15($cos(ang)), q15($sin(ang))};
    end
    for (int k = 0; k < DIM / 2 - 1; k++) begin
      ang = g * (k + 1) * phi;
      coef[(DIM/2 + k)*32 +: 32] = {q15($cos(ang)), q15($sin(ang))};
    end
    jn = 0;
    mult = phi * phi;
    for (int k = 0; k < DIM; k++) used[k] = 1'b0;
    for (int k = 0; k < DIM; k++) begin
      if (!used[k] && !used[(k+Q) % DIM]) begin
        used[k] = 1'b1;
        used[(k+Q) % DIM] = 1'b1;
        ang = g * (k + 1) * mult;
        coef[(DIM - 1 + jn)*32 +: 32] = {q15($cos(ang)), q15($sin(ang))};
        jn++;
      end
    end
  endtask

  function automatic void rnd_vec(output vec_t v, input int mag);
    for (int i = 0; i < DIM; i++) begin
      lcg = lcg * 1103515245 + 12345;
      v[i] = ((lcg >>> 8) % mag);
    end
  endfunction

  // ---------------- monitors ----------------
  always @(negedge clk) begin
    if (!rst && out_valid && out_ready) begin
      n_chk++;
      if (expq.size() == 0) begin
        n_fail++;
        $display("FAIL R8 unexpected output: actual %h expected none", out_vec);
      end else begin
        exp_e = expq.pop_front();
        if ({out_inverse, out_vec} !== exp_e) begin
          n_fail++;
          $display("FAIL %s: actual %h expected %h", tag, {out_inverse, out_vec}, exp_e);
        end
      end
      unpack(out_vec, last_out);
      if (pops == 0) first_pop = cyc;
      last_pop = cyc;
      pops++;
    end
  end

  always @(negedge clk) begin
    if (!rst && held) begin
      n_chk++;
      if (!(out_valid && out_vec === held_vec)) begin
        n_fail++;
        $display("FAIL R8 stall hold: actual %h expected %h", out_vec, held_vec);
      end
    end
    held     = !rst && out_valid && !out_ready;
    held_vec = out_vec;
  end

  // ---------------- drivers (called at posedge + 1) ----------------
  task automatic send(input vec_t v, input bit inv);
    vec_t ex;
    model(v, inv, ex);
    in_vec     = pack(v);
    in_inverse = inv;
    in_valid   = 1'b1;
    forever begin
      @(negedge clk);
      if (in_ready) break;
    end
    expq.push_back({inv, pack(ex)});
    acc_cyc = cyc;
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  task automatic drain();
    while (expq.size() != 0) @(negedge clk);
    @(posedge clk);
    #1;
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1 out_valid in reset", longint'(out_valid), 0);
    check(in_ready == 1'b1, "R1 in_ready in reset", longint'(in_ready), 1);
    @(posedge clk);
    #1;
    rst = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0, "R1 out_valid after reset", longint'(out_valid), 0);
    @(posedge clk);
    #1;
  endtask

  task automatic t_impulses();
    vec_t v;
    tag = "R2,R3,R4,R5,R9,R11 impulse";
    for (int i = 0; i < DIM; i++) v[i] = 0;
    v[0] = 16384;       send(v, 1'b0);
    v[0] = 0; v[DIM-1] = -16384; send(v, 1'b0);
    v[DIM-1] = 0; v[5] = 12000;  send(v, 1'b1);
    drain();
  endtask

  task automatic t_patterns();
    vec_t v;
    tag = "R5,R6,R9 pattern";
    for (int i = 0; i < DIM; i++) v[i] = (i - DIM/2) * 1500;
    send(v, 1'b0); send(v, 1'b1);
    for (int i = 0; i < DIM; i++) v[i] = (i % 2 == 0) ? 32767 : -32768;
    send(v, 1'b0); send(v, 1'b1);
    for (int n = 0; n < 6; n++) begin
      rnd_vec(v, 32768);
      send(v, n[0]);
    end
    drain();
  endtask

  task automatic t_latency();
    vec_t v;
    tag = "R7 latency";
    rnd_vec(v, 8192);
    send(v, 1'b0);
    drain();
    check(last_pop - acc_cyc == 3, "R7 latency edges", last_pop - acc_cyc, 3);
  endtask

  task automatic t_throughput();
    vec_t v;
    tag = "R7 stream";
    pops = 0;
    for (int n = 0; n < 8; n++) begin
      rnd_vec(v, 16384);
      send(v, n[1]);
    end
    drain();
    check(pops == 8, "R7 stream count", pops, 8);
    check(last_pop - first_pop == 7, "R7 one per cycle", last_pop - first_pop, 7);
  endtask

  task automatic t_backpressure();
    vec_t v;
    tag = "R8,R9 stalled stream";
    pops = 0;
    stall_en = 1'b1;
    for (int n = 0; n < 10; n++) begin
      rnd_vec(v, 20000);
      send(v, n[0]);
    end
    drain();
    stall_en = 1'b0;
    @(posedge clk);
    #1;
    check(pops == 10, "R8 no loss under stall", pops, 10);
  endtask

  task automatic t_roundtrip();
    vec_t v, fw;
    longint ni, no, d;
    int worst;
    tag = "R6,R10 roundtrip";
    for (int n = 0; n < 4; n++) begin
      rnd_vec(v, 8192);
      send(v, 1'b0);
      drain();
      fw = last_out;
      ni = norm2(v);
      no = norm2(fw);
      d  = (no > ni) ? no - ni : ni - no;
      check(d <= ni / 256 + 65536, "R10 norm kept", no, ni);
      send(fw, 1'b1);
      drain();
      worst = 0;
      for (int i = 0; i < DIM; i++) begin
        int e = (last_out[i] > v[i]) ? last_out[i] - v[i] : v[i] - last_out[i];
        if (e > worst) worst = e;
      end
      check(worst <= 8, "R6 roundtrip max error", worst, 8);
    end
  endtask

  task automatic t_determinism();
    vec_t v, first;
    tag = "R12 repeat";
    rnd_vec(v, 30000);
    send(v, 1'b0);
    drain();
    first = last_out;
    rnd_vec(v, 30000);
    send(v, 1'b1);
    drain();
    for (int i = 0; i < DIM; i++) v[i] = 0;
    rnd_vec(v, 30000);
    lcg = 777;
    rnd_vec(v, 30000);
    send(v, 1'b0);
    drain();
    first = last_out;
    lcg = 777;
    rnd_vec(v, 30000);
    send(v, 1'b0);
    drain();
    check(pack(first) == pack(last_out), "R12 identical output", longint'(last_out[0]), longint'(first[0]));
  endtask

  task automatic t_saturation();
    vec_t v;
    tag = "R5 saturation";
    for (int n = 0; n < NP; n++)
      coef[n*32 +: 32] = (n < DIM/2) ? {16'sd23170, 16'sd23170} : {16'sd32767, 16'sd0};
    for (int i = 0; i < DIM; i++) v[i] = 32767;
    send(v, 1'b0);
    for (int i = 0; i < DIM; i++) v[i] = -32768;
    send(v, 1'b1);
    drain();
    check(last_out[DIM-1] != 0, "R5 saturated lane nonzero", last_out[DIM-1], 1);
    golden_rom();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    golden_rom();
    t_reset();
    t_impulses();
    t_patterns();
    t_latency();
    t_throughput();
    t_backpressure();
    t_roundtrip();
    t_determinism();
    t_saturation();
    repeat (4) @(posedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule